// File: doc/BRIEF.md
# Static Memory Read Cycle Sequencer

This block performs a single read access on an external asynchronous static memory. A one-cycle request carries a byte address, a chip-select index and a device width code. The block drives the address and the active-low byte selects, then shapes two active-low strobes: a read strobe and a chip-select strobe. Each strobe has its own programmable delay and low time, measured in master-clock cycles. Both strobes sit inside one shared access length.

When the read strobe returns high, the block latches the 32-bit data bus. For narrow devices it right-aligns the captured data and zero-extends it. It then raises a one-cycle completion pulse, and the read word is presented with that pulse. The address lines are masked to suit the device width, so that 16-bit and 32-bit parts see word-aligned addresses. A host controller places this block behind its bus decoder, and it needs one instance for each static memory port.

Top module: `static_rd_seq`

## Requirements
- R1: After reset the strobes are high (mem_rd_n=1, all mem_cs_n bits 1), busy=0, done=0, mem_addr=0 and mem_bs_n=4'b1111.
- R2: A request accepted while idle makes busy high for exactly L cycles, where L = t_cycle, or 1 when t_cycle is 0. Access cycle k=0 is the cycle right after the accepting edge. done is high for exactly the one cycle after the last access cycle, and busy is low in that cycle.
- R3: The outputs mem_addr and mem_bs_n load at the accepting edge and then stay unchanged until the next accepted request. Width code 0 (8-bit) gives the full address and mem_bs_n=4'b1110. Code 1 (16-bit) clears address bit 0 and gives 4'b1100. Codes 2 (32-bit) and 3 (reserved, treated as 32-bit) clear bits 1:0 and give 4'b0000.
- R4: mem_rd_n is low in access cycle k exactly when t_rd_setup <= k < t_rd_setup + t_rd_pulse and k < L.
- R5: Only the selected line mem_cs_n[req_cs] can go low. It is low in access cycle k exactly when t_cs_setup <= k < t_cs_setup + t_cs_pulse and k < L. All other lines stay high.
- R6: Whenever busy is low, both strobes are high. A strobe window that extends past L is cut off at the end of the access.
- R7: mem_din is captured at the clock edge that ends the last low cycle of mem_rd_n. For width code 0 the result is {24'b0, mem_din[7:0]}, for code 1 it is {16'b0, mem_din[15:0]}, and for codes 2 and 3 it is the full bus. The result is shown on rdata from that edge on. If the read strobe never goes low, rdata keeps its previous value.
- R8: A request that arrives while busy is high is ignored: the address does not change and no new access follows.
- R9: A request whose chip-select index is NUM_CS or more is ignored: busy stays low and the address does not change.
- R10: The timing inputs are sampled only at the accepting edge. Changing them during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_addr | input | ADDR_W | Byte address of the access |
| req_cs | input | CS_W | Chip-select index |
| req_width | input | 2 | Device width code: 0=8, 1=16, 2=32, 3=32 |
| t_rd_setup | input | CNT_W | Read strobe delay in cycles |
| t_rd_pulse | input | CNT_W | Read strobe low time in cycles |
| t_cs_setup | input | CNT_W | Chip-select delay in cycles |
| t_cs_pulse | input | CNT_W | Chip-select low time in cycles |
| t_cycle | input | CNT_W | Access length in cycles (0 counts as 1) |
| busy | output | 1 | Access in progress |
| done | output | 1 | Completion pulse, rdata valid |
| rdata | output | DATA_W | Captured, aligned read word |
| mem_addr | output | ADDR_W | External address bus |
| mem_bs_n | output | 4 | Active-low byte selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_din | input | DATA_W | External data bus |

## Verification
The properties assume that req_valid is a clean synchronous pulse. They also assume that the index and width fields are meaningful whenever req_valid is high. No stable-data assumption is placed on mem_din, because capture is judged only at the strobe's rising edge. The stimulus drives every input half a cycle away from the active edge. It changes mem_din in every access cycle, so a capture made in the wrong cycle returns a visibly different word. The timing inputs are drawn from ranges that cover zero setups, zero pulses and windows longer than the access.

// File: rtl/static_rd_seq_pkg.sv
package static_rd_seq_pkg;

   typedef enum logic [1:0] {
      DW_8   = 2'd0,
      DW_16  = 2'd1,
      DW_32  = 2'd2,
      DW_RSV = 2'd3
   } dev_width_e;

   function automatic logic [3:0] lane_sel_n(input dev_width_e w);
      case (w)
         DW_8:    return 4'b1110;
         DW_16:   return 4'b1100;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/srs_addr_fmt.sv
module srs_addr_fmt
   import static_rd_seq_pkg::*;
#(
   parameter int ADDR_W = 26
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  dev_width_e        width,
   output logic [ADDR_W-1:0] addr_out,
   output logic [3:0]        bs_n_out
);

   localparam logic [ADDR_W-1:0] MASK16 = ~(ADDR_W'(1));
   localparam logic [ADDR_W-1:0] MASK32 = ~(ADDR_W'(3));

   always_comb begin
      case (width)
         DW_8:    addr_out = addr_in;
         DW_16:   addr_out = addr_in & MASK16;
         default: addr_out = addr_in & MASK32;
      endcase
      bs_n_out = lane_sel_n(width);
   end

endmodule

// File: rtl/srs_data_align.sv
module srs_data_align
   import static_rd_seq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] bus_in,
   input  dev_width_e        width,
   output logic [DATA_W-1:0] word_out
);

   localparam int HALF_W = DATA_W / 2;
   localparam int BYTE_W = 8;

   always_comb begin
      case (width)
         DW_8:    word_out = {{(DATA_W-BYTE_W){1'b0}}, bus_in[BYTE_W-1:0]};
         DW_16:   word_out = {{(DATA_W-HALF_W){1'b0}}, bus_in[HALF_W-1:0]};
         default: word_out = bus_in;
      endcase
   end

endmodule

// File: rtl/srs_strobe_win.sv
module srs_strobe_win #(
   parameter int CNT_W = 6
) (
   input  logic             active,
   input  logic             last,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] setup,
   input  logic [CNT_W-1:0] pulse,
   output logic             low,
   output logic             rise
);

   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] cnt_x;
   logic [EXT_W-1:0] start_x;
   logic [EXT_W-1:0] stop_x;

   always_comb begin
      cnt_x   = {1'b0, cnt};
      start_x = {1'b0, setup};
      stop_x  = {1'b0, setup} + {1'b0, pulse};
      low     = active && (cnt_x >= start_x) && (cnt_x < stop_x);
      rise    = low && (((cnt_x + EXT_W'(1)) == stop_x) || last);
   end

endmodule

// File: rtl/srs_cycle_ctl.sv
module srs_cycle_ctl #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_in,
   output logic             busy,
   output logic             last,
   output logic             done,
   output logic [CNT_W-1:0] cnt
);

   logic [CNT_W-1:0] len_q;

   assign last = busy && (cnt == (len_q - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         cnt   <= '0;
         len_q <= CNT_W'(1);
      end else begin
         done <= last;
         if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            len_q <= (len_in == '0) ? CNT_W'(1) : len_in;
         end else if (busy) begin
            if (last) busy <= 1'b0;
            else      cnt  <= cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/static_rd_seq.sv
module static_rd_seq
   import static_rd_seq_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32,
   parameter int NUM_CS = 6,
   parameter int CNT_W  = 6,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [1:0]        req_width,
   input  logic [CNT_W-1:0]  t_rd_setup,
   input  logic [CNT_W-1:0]  t_rd_pulse,
   input  logic [CNT_W-1:0]  t_cs_setup,
   input  logic [CNT_W-1:0]  t_cs_pulse,
   input  logic [CNT_W-1:0]  t_cycle,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_bs_n,
   output logic              mem_rd_n,
   output logic [NUM_CS-1:0] mem_cs_n,
   input  logic [DATA_W-1:0] mem_din
);

   if (DATA_W != 32) begin : g_bad_data_w
      $error("static_rd_seq: DATA_W must be 32");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("static_rd_seq: ADDR_W must be at least 3");
   end
   if (NUM_CS < 1) begin : g_bad_num_cs
      $error("static_rd_seq: NUM_CS must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("static_rd_seq: CNT_W must be at least 2");
   end

   logic              accept;
   logic              last;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  rd_set_q, rd_pul_q, cs_set_q, cs_pul_q;
   logic [CS_W-1:0]   cs_q;
   dev_width_e        width_q;
   dev_width_e        req_w;
   logic [ADDR_W-1:0] fmt_addr;
   logic [3:0]        fmt_bs_n;
   logic [DATA_W-1:0] aligned;
   logic [DATA_W-1:0] rdata_q;
   logic              rd_low, rd_rise, cs_low, cs_rise_unused;

   assign req_w  = dev_width_e'(req_width);
   assign accept = req_valid && !busy && (int'(req_cs) < NUM_CS);

   srs_cycle_ctl #(.CNT_W(CNT_W)) i_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .len_in (t_cycle),
      .busy   (busy),
      .last   (last),
      .done   (done),
      .cnt    (cnt)
   );

   srs_addr_fmt #(.ADDR_W(ADDR_W)) i_fmt (
      .addr_in  (req_addr),
      .width    (req_w),
      .addr_out (fmt_addr),
      .bs_n_out (fmt_bs_n)
   );

   srs_data_align #(.DATA_W(DATA_W)) i_align (
      .bus_in   (mem_din),
      .width    (width_q),
      .word_out (aligned)
   );

   srs_strobe_win #(.CNT_W(CNT_W)) i_rd_win (
      .active (busy),
      .last   (last),
      .cnt    (cnt),
      .setup  (rd_set_q),
      .pulse  (rd_pul_q),
      .low    (rd_low),
      .rise   (rd_rise)
   );

   srs_strobe_win #(.CNT_W(CNT_W)) i_cs_win (
      .active (busy),
      .last   (last),
      .cnt    (cnt),
      .setup  (cs_set_q),
      .pulse  (cs_pul_q),
      .low    (cs_low),
      .rise   (cs_rise_unused)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_set_q <= '0;
         rd_pul_q <= '0;
         cs_set_q <= '0;
         cs_pul_q <= '0;
         cs_q     <= '0;
         width_q  <= DW_32;
         mem_addr <= '0;
         mem_bs_n <= 4'b1111;
      end else if (accept) begin
         rd_set_q <= t_rd_setup;
         rd_pul_q <= t_rd_pulse;
         cs_set_q <= t_cs_setup;
         cs_pul_q <= t_cs_pulse;
         cs_q     <= req_cs;
         width_q  <= req_w;
         mem_addr <= fmt_addr;
         mem_bs_n <= fmt_bs_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_rise) rdata_q <= aligned;
   end

   assign rdata    = rdata_q;
   assign mem_rd_n = ~rd_low;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign mem_cs_n[i] = ~(cs_low && (cs_q == CS_W'(i)));
   end

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
   parameter int ADDR_W = 26,
   parameter int NUM_CS = 6,
   parameter int CS_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [CS_W-1:0]   req_cs,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        mem_bs_n,
   input logic              mem_rd_n,
   input logic [NUM_CS-1:0] mem_cs_n
);

   // R6: strobes idle high outside an access
   a_r6_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_rd_n && (&mem_cs_n)));

   // R5: at most one chip select active
   a_r5_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   // R3: address and lane selects hold during an access
   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_bs_n)));

   // R2: done follows the end of busy and lasts one cycle
   a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: request while busy does not reload the address
   a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> $stable(mem_addr));

   // R9: out-of-range index never starts an access
   a_r9_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && (int'(req_cs) >= NUM_CS)) |=> !busy);

endmodule

bind static_rd_seq srs_checker #(
   .ADDR_W (ADDR_W),
   .NUM_CS (NUM_CS),
   .CS_W   (CS_W)
) i_srs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_cs    (req_cs),
   .busy      (busy),
   .done      (done),
   .mem_addr  (mem_addr),
   .mem_bs_n  (mem_bs_n),
   .mem_rd_n  (mem_rd_n),
   .mem_cs_n  (mem_cs_n)
);

// File: tb/test_static_rd_seq.sv
module test_static_rd_seq;

   localparam int ADDR_W = 26;
   localparam int DATA_W = 32;
   localparam int NUM_CS = 6;
   localparam int CNT_W  = 6;
   localparam int CS_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [CS_W-1:0]   req_cs = '0;
   logic [1:0]        req_width = '0;
   logic [CNT_W-1:0]  t_rd_setup = '0, t_rd_pulse = '0, t_cs_setup = '0, t_cs_pulse = '0, t_cycle = '0;
   logic              busy, done, mem_rd_n;
   logic [DATA_W-1:0] rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic [3:0]        mem_bs_n;
   logic [NUM_CS-1:0] mem_cs_n;
   logic [DATA_W-1:0] mem_din = '0;

   int checks = 0;
   int failures = 0;
   logic [DATA_W-1:0] prev_rdata = '0;

   always #4 clk = ~clk;

   static_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CNT_W(CNT_W)) i_static_rd_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_cs(req_cs),
      .req_width(req_width), .t_rd_setup(t_rd_setup), .t_rd_pulse(t_rd_pulse),
      .t_cs_setup(t_cs_setup), .t_cs_pulse(t_cs_pulse), .t_cycle(t_cycle),
      .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_bs_n(mem_bs_n),
      .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n), .mem_din(mem_din)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] a, input logic [1:0] w);
      if (w == 2'd0) return a;
      if (w == 2'd1) return a & ~(ADDR_W'(1));
      return a & ~(ADDR_W'(3));
   endfunction

   function automatic logic [3:0] exp_bs(input logic [1:0] w);
      if (w == 2'd0) return 4'b1110;
      if (w == 2'd1) return 4'b1100;
      return 4'b0000;
   endfunction

   function automatic logic [DATA_W-1:0] exp_align(input logic [DATA_W-1:0] d, input logic [1:0] w);
      if (w == 2'd0) return {24'b0, d[7:0]};
      if (w == 2'd1) return {16'b0, d[15:0]};
      return d;
   endfunction

   function automatic logic [DATA_W-1:0] dval(input logic [DATA_W-1:0] base, input int k);
      return base + DATA_W'(k) * 32'h9E3779B9;
   endfunction

   task automatic do_access(input logic [ADDR_W-1:0] a, input int cs, input logic [1:0] w,
                            input int rs, input int rp, input int css, input int csp, input int len);
      int L;
      int cap_k;
      int stop;
      logic [DATA_W-1:0] base;
      logic [ADDR_W-1:0] ea;
      logic [DATA_W-1:0] er;
      L = (len == 0) ? 1 : len;
      base = $urandom;
      ea = exp_addr(a, w);
      stop = (rs + rp < L) ? rs + rp : L;
      cap_k = (rp != 0 && rs < L) ? stop - 1 : -1;
      er = (cap_k >= 0) ? exp_align(dval(base, cap_k), w) : prev_rdata;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_cs = CS_W'(cs); req_width = w;
      t_rd_setup = CNT_W'(rs); t_rd_pulse = CNT_W'(rp);
      t_cs_setup = CNT_W'(css); t_cs_pulse = CNT_W'(csp); t_cycle = CNT_W'(len);
      @(negedge clk);
      for (int k = 0; k < L; k++) begin
         logic [NUM_CS-1:0] ecs;
         req_valid = 1'b0;
         // R10: scramble timing inputs during the access
         t_rd_setup = CNT_W'($urandom); t_rd_pulse = CNT_W'($urandom);
         t_cs_setup = CNT_W'($urandom); t_cs_pulse = CNT_W'($urandom);
         t_cycle = CNT_W'($urandom);
         mem_din = dval(base, k);
         ecs = '1;
         if (k >= css && k < css + csp) ecs[cs] = 1'b0;
         check("R2 busy during access", 64'(busy), 64'd1);
         check("R2 done low during access", 64'(done), 64'd0);
         check("R3 address", 64'(mem_addr), 64'(ea));
         check("R3 byte selects", 64'(mem_bs_n), 64'(exp_bs(w)));
         check("R4 read strobe R10", 64'(mem_rd_n), 64'(!(k >= rs && k < rs + rp)));
         check("R5 chip selects R10", 64'(mem_cs_n), 64'(ecs));
         if (k == 1) begin
            // R8: request during busy
            req_valid = 1'b1; req_addr = ~a; req_cs = CS_W'((cs + 1) % NUM_CS); req_width = 2'd0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      check("R2 done pulse", 64'(done), 64'd1);
      check("R2 busy low at done", 64'(busy), 64'd0);
      check("R7 read data", 64'(rdata), 64'(er));
      check("R6 strobes idle", 64'({mem_rd_n, mem_cs_n}), 64'({1'b1, {NUM_CS{1'b1}}}));
      check("R3 address held", 64'(mem_addr), 64'(ea));
      prev_rdata = er;
      @(negedge clk);
      check("R2 done single cycle", 64'(done), 64'd0);
      check("R8 no access after busy request", 64'(busy), 64'd0);
      check("R8 address unchanged", 64'(mem_addr), 64'(ea));
   endtask

   initial begin
      logic [ADDR_W-1:0] keep;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      check("R1 rd strobe", 64'(mem_rd_n), 64'd1);
      check("R1 chip selects", 64'(mem_cs_n), 64'({NUM_CS{1'b1}}));
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 done", 64'(done), 64'd0);
      check("R1 address", 64'(mem_addr), 64'd0);
      check("R1 byte selects", 64'(mem_bs_n), 64'hF);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      do_access(26'h3ABCDEF, 0, 2'd0, 0, 3, 0, 4, 5);   // zero setup, 8-bit
      do_access(26'h1234567, 5, 2'd1, 2, 2, 1, 4, 6);   // 16-bit, last select
      do_access(26'h2FFFFFF, 3, 2'd2, 3, 9, 2, 9, 6);   // R6 truncation
      do_access(26'h0000003, 1, 2'd3, 0, 1, 0, 1, 0);   // length 0 -> 1, reserved width
      do_access(26'h155AA55, 2, 2'd2, 2, 0, 0, 0, 4);   // R7 no capture
      do_access(26'h0ABCDE1, 4, 2'd2, 7, 2, 1, 1, 4);   // R7 strobe starts past end
      // R9: out-of-range index
      keep = mem_addr;
      req_valid = 1'b1; req_addr = 26'h1111111; req_cs = 3'd6; req_width = 2'd0; t_cycle = 6'd4;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 busy stays low", 64'(busy), 64'd0);
      check("R9 address unchanged", 64'(mem_addr), 64'(keep));
      req_valid = 1'b1; req_cs = 3'd7;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 index 7 ignored", 64'(busy), 64'd0);
      // random accesses
      for (int n = 0; n < 60; n++) begin
         do_access(ADDR_W'($urandom), int'($urandom_range(0, NUM_CS - 1)), 2'($urandom_range(0, 2)),
                   int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
                   int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
                   int'($urandom_range(0, 14)));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule